// File: doc/BRIEF.md
# Two-Phase Hall Commutation Sequencer

This block drives the two low-side stator windings of a two-phase brushless fan from the sign of a Hall comparator. The raw comparator level first passes through a two-flop synchronizer. A polarity change is then accepted only after it has held for a qualifying run of clock cycles, so noise near the zero crossing cannot commutate the motor.

When a change is accepted, the winding that was conducting is released at once. The opposite winding is switched on only after a break-before-make dead time. This leaves room for the flyback energy of the released winding to be clamped before the other winding conducts.

A global drive enable forces both windings off at once. When the enable returns, drive resumes through a dead time. An open-drain tachometer enable and the qualified Hall level are also provided for neighbouring logic. With a four-pole rotor, the tachometer gives two low pulses per revolution.

Top module: `hall_commutator`

## Requirements
- R1: While driving, `phaseBOn` is high when the qualified level `hallLevel` is 1 (positive Hall difference), and `phaseAOn` is high when `hallLevel` is 0.
- R2: `hallLevel` takes a new value only after `hallIn` has been sampled at that value on DEG consecutive rising edges, where DEG = CLK_MHZ*DEGLITCH_NS/1000. The update appears two edges after the last qualifying sample, because of the synchronizer. A run of DEG-1 samples leaves `hallLevel` and both phases unchanged.
- R3: In the cycle in which `hallLevel` changes, the phase that was conducting is off.
- R4: After `hallLevel` changes, neither phase conducts until the opposite phase turns on. It turns on at the (DEAD+1)th rising edge after the edge that updated `hallLevel`, where DEAD = CLK_MHZ*DEAD_NS/1000.
- R5: `phaseAOn` and `phaseBOn` are never high together.
- R6: `tachPullLow` is 1 exactly when a level has been qualified since reset and `hallLevel` is 0; otherwise it is 0 (released).
- R7: While `driveEn` is low, both phase outputs are low in the same cycle, with no clock edge needed.
- R8: After `driveEn` returns high, the phase matching the current `hallLevel` turns on at the (DEAD+1)th rising edge that samples `driveEn` high.
- R9: During and after reset, all outputs are 0. No phase turns on before the first level has been qualified by a full DEG run and a dead time has elapsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hallIn | input | 1 | Raw Hall comparator level, 1 = positive difference |
| driveEn | input | 1 | Global drive enable, active high |
| phaseAOn | output | 1 | Phase A low-side switch on |
| phaseBOn | output | 1 | Phase B low-side switch on |
| tachPullLow | output | 1 | Tachometer open-drain pull-down enable |
| hallLevel | output | 1 | Qualified Hall level for other blocks |

## Verification
The assertions watch the following on every cycle:
- Whenever a phase conducts, it agrees with the qualified level.
- A disable forces both outputs off.
- Any switch-on is preceded by an expired dead-time count.
- One phase is never followed directly by the other.
- A qualified level only ever takes the value the synchronizer last presented, and the level stays valid once set.

The exact cycle counts need the bench's scenarios, which compare against a behavioural model on every cycle. These counts are the DEG-1 versus DEG run boundary, the commutation gap, the restart delay after a disable, and the initial qualification after reset.

// File: rtl/hall_seq_pkg.sv
package hall_seq_pkg;

  // Strobes from the sequencing control to the counting datapath
  typedef struct packed {
    logic startDead;
  } ctlStrobe_t;

  // Status returned by the datapath
  typedef struct packed {
    logic levelValid;
    logic level;
    logic deadDone;
  } dpStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DEAD = 2'd1,
    ST_ON   = 2'd2
  } phaseState_t;

endpackage

// File: rtl/hall_seq_datapath.sv
module hall_seq_datapath
  import hall_seq_pkg::*;
#(
  parameter int DG_CYC   = 5000,
  parameter int DEAD_CYC = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hallIn,
  input  ctlStrobe_t ctl,
  output dpStatus_t  status
);

  localparam int SYNC_DEPTH = 2;
  localparam int DGW = $clog2(DG_CYC + 1);
  localparam int DTW = $clog2(DEAD_CYC + 1);

  logic [SYNC_DEPTH-1:0] syncQ;
  logic                  sampled;
  logic                  candQ;
  logic                  levelQ;
  logic                  validQ;
  logic [DGW-1:0]        glitchCnt;
  logic [DTW-1:0]        deadCnt;
  logic                  deadRun;

  // Synchronizer for the asynchronous comparator level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_DEPTH-2:0], hallIn};
  end
  assign sampled = syncQ[SYNC_DEPTH-1];

  // Run-length qualification of a new polarity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candQ     <= 1'b0;
      levelQ    <= 1'b0;
      validQ    <= 1'b0;
      glitchCnt <= '0;
    end else if (sampled != candQ) begin
      candQ     <= sampled;
      glitchCnt <= DGW'(1);
    end else if (validQ && (sampled == levelQ)) begin
      glitchCnt <= '0;
    end else if (glitchCnt == DGW'(DG_CYC - 1)) begin
      levelQ    <= sampled;
      validQ    <= 1'b1;
      glitchCnt <= '0;
    end else begin
      glitchCnt <= glitchCnt + 1'b1;
    end
  end

  // Break-before-make interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deadCnt <= '0;
      deadRun <= 1'b0;
    end else if (ctl.startDead) begin
      deadCnt <= DTW'(DEAD_CYC - 1);
      deadRun <= 1'b1;
    end else if (deadRun) begin
      if (deadCnt == '0) deadRun <= 1'b0;
      else               deadCnt <= deadCnt - 1'b1;
    end
  end

  always_comb begin
    status.levelValid = validQ;
    status.level      = levelQ;
    status.deadDone   = deadRun && (deadCnt == '0);
  end

  // R2
  level_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelQ != $past(levelQ)) |-> ($past(sampled) == levelQ));

  // R9
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    validQ |=> validQ);

endmodule

// File: rtl/hall_seq_control.sv
module hall_seq_control
  import hall_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       driveEn,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output logic       phaseAOn,
  output logic       phaseBOn
);

  phaseState_t stateQ, stateNext;
  logic        onLvlQ;
  logic        drive;

  always_comb begin
    stateNext     = stateQ;
    ctl           = '0;
    case (stateQ)
      ST_IDLE: begin
        if (driveEn && status.levelValid) begin
          stateNext     = ST_DEAD;
          ctl.startDead = 1'b1;
        end
      end
      ST_DEAD: begin
        if (!driveEn)             stateNext = ST_IDLE;
        else if (status.deadDone) stateNext = ST_ON;
      end
      ST_ON: begin
        if (!driveEn) begin
          stateNext = ST_IDLE;
        end else if (status.level != onLvlQ) begin
          stateNext     = ST_DEAD;
          ctl.startDead = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      onLvlQ <= 1'b0;
    end else begin
      stateQ <= stateNext;
      if (stateQ == ST_DEAD && stateNext == ST_ON) onLvlQ <= status.level;
    end
  end

  // Drop the conducting phase the moment the qualified level moves
  assign drive    = driveEn && (stateQ == ST_ON) && (status.level == onLvlQ);
  assign phaseBOn = drive && status.level;
  assign phaseAOn = drive && !status.level;

  // R1
  phase_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseAOn || phaseBOn) |-> (phaseBOn == status.level));

  // R4
  dead_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phaseAOn || phaseBOn) |-> $past(status.deadDone));

  // R4
  a_then_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseAOn |=> !phaseBOn);

  // R4
  b_then_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseBOn |=> !phaseAOn);

  // R7
  enable_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !driveEn |-> !(phaseAOn || phaseBOn));

endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
  import hall_seq_pkg::*;
#(
  parameter int CLK_MHZ     = 200,
  parameter int DEGLITCH_NS = 25000,
  parameter int DEAD_NS     = 5000
) (
  input  logic clk,
  input  logic rstN,
  input  logic hallIn,
  input  logic driveEn,
  output logic phaseAOn,
  output logic phaseBOn,
  output logic tachPullLow,
  output logic hallLevel
);

  localparam int DG_CYC   = CLK_MHZ * DEGLITCH_NS / 1000;
  localparam int DEAD_CYC = CLK_MHZ * DEAD_NS / 1000;

  ctlStrobe_t ctl;
  dpStatus_t  status;

  hall_seq_datapath #(
    .DG_CYC  (DG_CYC),
    .DEAD_CYC(DEAD_CYC)
  ) uDatapath (
    .clk   (clk),
    .rstN  (rstN),
    .hallIn(hallIn),
    .ctl   (ctl),
    .status(status)
  );

  hall_seq_control uControl (
    .clk     (clk),
    .rstN    (rstN),
    .driveEn (driveEn),
    .status  (status),
    .ctl     (ctl),
    .phaseAOn(phaseAOn),
    .phaseBOn(phaseBOn)
  );

  assign hallLevel   = status.level;
  assign tachPullLow = status.levelValid && !status.level;

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(phaseAOn && phaseBOn));

endmodule

// File: tb/tb_hall_commutator.sv
`timescale 1ns/1ps
module tb_hall_commutator;

  localparam int CLK_MHZ = 200;
  localparam int DEG_NS  = 100;
  localparam int DEAD_NS = 30;
  localparam int DG = CLK_MHZ * DEG_NS / 1000;   // 20 cycles
  localparam int DT = CLK_MHZ * DEAD_NS / 1000;  // 6 cycles

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hallIn = 1'b0;
  logic driveEn = 1'b0;
  logic phaseAOn, phaseBOn, tachPullLow, hallLevel;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string curReq = "R9";

  // Behavioural reference state
  int mS1 = 0, mS2 = 0, mLast = 0, mRun = 0, mLevel = 0, mValid = 0;
  int mState = 0, mOnLvl = 0, mDeadLeft = 0, mDeadRun = 0;

  always #2.5 clk = ~clk;

  hall_commutator #(
    .CLK_MHZ    (CLK_MHZ),
    .DEGLITCH_NS(DEG_NS),
    .DEAD_NS    (DEAD_NS)
  ) dut (
    .clk        (clk),
    .rstN       (rstN),
    .hallIn     (hallIn),
    .driveEn    (driveEn),
    .phaseAOn   (phaseAOn),
    .phaseBOn   (phaseBOn),
    .tachPullLow(tachPullLow),
    .hallLevel  (hallLevel)
  );

  always @(posedge clk) begin : model
    int deadDone;
    int start;
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mLast = 0; mRun = 0; mLevel = 0; mValid = 0;
      mState = 0; mOnLvl = 0; mDeadLeft = 0; mDeadRun = 0;
    end else begin
      deadDone = (mDeadRun != 0 && mDeadLeft == 0) ? 1 : 0;
      start = 0;
      if (mState == 0) begin
        if (driveEn && mValid != 0) begin mState = 1; start = 1; end
      end else if (mState == 1) begin
        if (!driveEn) mState = 0;
        else if (deadDone != 0) begin mState = 2; mOnLvl = mLevel; end
      end else begin
        if (!driveEn) mState = 0;
        else if (mLevel != mOnLvl) begin mState = 1; start = 1; end
      end
      if (start != 0) begin mDeadLeft = DT - 1; mDeadRun = 1; end
      else if (mDeadRun != 0) begin
        if (mDeadLeft == 0) mDeadRun = 0; else mDeadLeft--;
      end
      if (mS2 != mLast) mRun = 1; else mRun++;
      mLast = mS2;
      if ((mValid == 0 || mS2 != mLevel) && mRun >= DG) begin
        mLevel = mS2; mValid = 1;
      end
      mS2 = mS1;
      mS1 = hallIn ? 1 : 0;
    end
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp();
    logic drv;
    drv = driveEn && mState == 2 && mLevel == mOnLvl;
    chk(phaseAOn, drv && mLevel == 0, curReq, "phaseAOn");
    chk(phaseBOn, drv && mLevel != 0, curReq, "phaseBOn");
    chk(tachPullLow, mValid != 0 && mLevel == 0, "R6", "tachPullLow");
    chk(hallLevel, mLevel != 0, "R2", "hallLevel");
    chk(!(phaseAOn && phaseBOn), 1'b1, "R5", "phase overlap");
  endtask

  task automatic cyc(input logic h, input logic e);
    @(negedge clk);
    cmp();
    hallIn = h;
    driveEn = e;
    #1;
    cmp();
  endtask

  task automatic hold(input logic h, input logic e, input int n);
    for (int i = 0; i < n; i++) cyc(h, e);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    bit anyOn, flag;
    int firstA, lastB, firstOn;

    // R9: reset state
    curReq = "R9";
    hold(1'b1, 1'b1, 4);
    chk(phaseAOn | phaseBOn | tachPullLow | hallLevel, 1'b0, "R9", "outputs in reset");
    rstN = 1'b1;
    anyOn = 0;
    for (int k = 0; k < DG + 2; k++) begin
      cyc(1'b1, 1'b1);
      if (phaseAOn || phaseBOn) anyOn = 1;
    end
    chk(anyOn, 1'b0, "R9", "phase before qualification");
    curReq = "R1";
    hold(1'b1, 1'b1, 40);
    chk(phaseBOn, 1'b1, "R1", "phaseBOn for positive level");

    // R2: excursion one cycle short of the qualifying run
    curReq = "R2";
    hold(1'b0, 1'b1, DG - 1);
    flag = 1;
    for (int k = 0; k < 30; k++) begin
      cyc(1'b1, 1'b1);
      if (!hallLevel || !phaseBOn) flag = 0;
    end
    chk(flag, 1'b1, "R2", "short excursion ignored");

    // R3 / R4: commutation gap from B to A
    curReq = "R4";
    firstA = -1; lastB = -1;
    for (int k = 1; k <= DG + DT + 12; k++) begin
      cyc(1'b0, 1'b1);
      if (phaseAOn && firstA < 0) firstA = k;
      if (phaseBOn) lastB = k;
    end
    chk(lastB == DG + 2, 1'b1, "R3", "phase B release cycle");
    if (lastB != DG + 2) $display("FAIL R3 lastB: actual %0d expected %0d", lastB, DG + 2);
    chk(firstA == DG + DT + 4, 1'b1, "R4", "phase A turn-on cycle");
    if (firstA != DG + DT + 4) $display("FAIL R4 firstA: actual %0d expected %0d", firstA, DG + DT + 4);

    // R2: run of exactly the qualifying length is accepted
    curReq = "R2";
    flag = 0;
    hold(1'b1, 1'b1, DG);
    for (int k = 0; k < 40; k++) begin
      cyc(1'b0, 1'b1);
      if (hallLevel) flag = 1;
    end
    chk(flag, 1'b1, "R2", "full-length run accepted");

    // R1 / R6: rotation at several speeds
    curReq = "R1";
    for (int i = 0; i < 8; i++) hold(logic'(i % 2 == 0), 1'b1, 30 + 7 * i);
    chk(tachPullLow, !hallLevel, "R6", "tach follows level");

    // R7: disable forces both phases off immediately
    curReq = "R7";
    cyc(1'b1, 1'b0);
    chk(phaseAOn | phaseBOn, 1'b0, "R7", "phases off at disable");
    hold(1'b1, 1'b0, 5);
    hold(1'b0, 1'b0, DG + 6);

    // R8: restart after one dead time with the current polarity
    curReq = "R8";
    firstOn = -1;
    for (int k = 1; k <= DT + 10; k++) begin
      cyc(1'b0, 1'b1);
      if ((phaseAOn || phaseBOn) && firstOn < 0) firstOn = k;
    end
    chk(firstOn == DT + 2, 1'b1, "R8", "restart cycle");
    if (firstOn != DT + 2) $display("FAIL R8 firstOn: actual %0d expected %0d", firstOn, DT + 2);
    chk(phaseAOn, 1'b1, "R8", "restart phase matches level");

    // R9: reset in the middle of driving
    curReq = "R9";
    rstN = 1'b0;
    hold(1'b0, 1'b1, 3);
    chk(phaseAOn | phaseBOn | tachPullLow | hallLevel, 1'b0, "R9", "outputs after mid-run reset");
    rstN = 1'b1;
    hold(1'b0, 1'b1, DG + DT + 10);
    chk(phaseAOn, 1'b1, "R9", "drive after requalification");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule